// File: doc/BRIEF.md
# Decode-Resolved Pipeline Hazard Controller

This block decides, every cycle, whether a five-stage in-order integer pipeline must freeze its front end or discard a fetched instruction. Branch comparison and jump target arithmetic sit in the decode stage. A branch or register-indirect jump therefore needs its operands earlier than an ordinary instruction, which receives forwarded data in execute. The controller looks at the source registers of the decode-stage instruction, at which of those sources that instruction really uses, and at its control-transfer class. It also looks at the destination, write enable and load flag of the instructions now in execute and memory.

Its four outputs are purely combinational and are sampled by the pipeline registers at the next clock edge. A stall holds the program counter and the fetch/decode register and places a bubble into decode/execute. A flush replaces the fetch/decode contents with a bubble, so a taken transfer costs exactly one fetch slot. When both are wanted, the stall takes precedence. The transfer resolves, and flushes, in the later cycle when its operands are ready.

Top module: `hzd_unit`

## Requirements
- R1: When the instruction in execute is a load (reg-write 1, mem-read 1) with a nonzero destination equal to a source that the decode instruction uses, pc_hold, ifid_hold and idex_bubble are all 1.
- R2: pc_hold, ifid_hold and idex_bubble always take the same value, and with idle stage inputs all four outputs are 0.
- R3: A branch or register-indirect jump in decode stalls when a used source equals the nonzero destination of any register-writing instruction in execute, whether or not it is a load.
- R4: A branch or register-indirect jump in decode stalls when a used source equals the nonzero destination of a load in memory; a non-load writer in memory causes no stall.
- R5: An instruction that is not a branch or register-indirect jump does not stall on a non-load writer in execute, nor on any writer in memory.
- R6: A destination index of 0 never causes a stall.
- R7: A source whose use flag is 0 never causes a stall, even if its index matches a destination.
- R8: With no stall, ifid_flush is 1 for a direct jump, for a register-indirect jump, and for a branch whose taken input is 1; it is 0 for a branch that is not taken and for any other instruction.
- R9: When a stall condition holds, ifid_flush is 0 even for a taken transfer.
- R10: An instruction in execute or memory whose reg-write flag is 0 never causes a stall, whatever its destination and load flag.
- R11: As the pipeline advances, a load followed directly by a dependent ordinary instruction stalls for one cycle. A load followed directly by a dependent branch stalls for two cycles, and the branch flushes in the third cycle if taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs1 | input | 5 | First source index of the decode instruction |
| id_rs2 | input | 5 | Second source index of the decode instruction |
| id_rs1_used | input | 1 | Decode instruction reads its first source |
| id_rs2_used | input | 1 | Decode instruction reads its second source |
| id_is_branch | input | 1 | Decode instruction is a conditional branch |
| id_is_jal | input | 1 | Decode instruction is a direct jump |
| id_is_jalr | input | 1 | Decode instruction is a register-indirect jump |
| id_branch_taken | input | 1 | Decode-stage comparison result for a branch |
| ex_rd | input | 5 | Destination index of the execute instruction |
| ex_reg_write | input | 1 | Execute instruction writes a register |
| ex_mem_read | input | 1 | Execute instruction is a load |
| mem_rd | input | 5 | Destination index of the memory-stage instruction |
| mem_reg_write | input | 1 | Memory-stage instruction writes a register |
| mem_mem_read | input | 1 | Memory-stage instruction is a load |
| pc_hold | output | 1 | Keep the program counter this cycle |
| ifid_hold | output | 1 | Keep the fetch/decode register this cycle |
| idex_bubble | output | 1 | Load a bubble into decode/execute |
| ifid_flush | output | 1 | Replace fetch/decode contents with a bubble |

## Verification
The checks assume that at most one of id_is_branch, id_is_jal and id_is_jalr is set. They also assume that the use flags agree with the class: a direct jump uses no source, a register-indirect jump only the first. A load flag is only set together with the write flag. Every stimulus task builds its stage contents from these legal combinations. In the sequence scenario, a bubble that enters execute appears with its write and load flags cleared, as the real datapath would present it.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

  localparam int REG_AW_DEF  = 5;
  localparam int NUM_SRC     = 2;
  localparam int NUM_WSTAGE  = 2;

  // producer stages that can still hold a result the decode stage needs
  typedef enum logic [0:0] {
    WST_EX  = 1'b0,
    WST_MEM = 1'b1
  } wstage_e;

  // control-transfer class of the decode instruction
  typedef enum logic [1:0] {
    XFER_NONE   = 2'd0,
    XFER_BRANCH = 2'd1,
    XFER_DIRECT = 2'd2,
    XFER_INDIR  = 2'd3
  } xfer_e;

  function automatic xfer_e classify(input logic br, input logic jal, input logic jalr);
    if (jalr)      return XFER_INDIR;
    else if (jal)  return XFER_DIRECT;
    else if (br)   return XFER_BRANCH;
    else           return XFER_NONE;
  endfunction

endpackage

// File: rtl/hzd_src_cmp.sv
module hzd_src_cmp #(
  parameter int AW = 5
) (
  input  logic [AW-1:0] src_idx,
  input  logic          src_used,
  input  logic [AW-1:0] wr_idx,
  input  logic          wr_en,
  output logic          hit
);
  localparam logic [AW-1:0] ZERO_IDX = '0;

  logic nonzero_dst;
  assign nonzero_dst = (wr_idx != ZERO_IDX);
  assign hit = src_used && wr_en && nonzero_dst && (src_idx == wr_idx);
endmodule

// File: rtl/hzd_stall_eval.sv
module hzd_stall_eval
  import hzd_pkg::*;
#(
  parameter int AW   = 5,
  parameter int NSRC = NUM_SRC
) (
  input  logic [NSRC-1:0][AW-1:0] src_idx,
  input  logic [NSRC-1:0]         src_used,
  input  logic                    early_need,
  input  logic [AW-1:0]           ex_rd,
  input  logic                    ex_wr,
  input  logic                    ex_ld,
  input  logic [AW-1:0]           mem_rd,
  input  logic                    mem_wr,
  input  logic                    mem_ld,
  output logic                    stall
);
  localparam int NW = NUM_WSTAGE;

  logic [NW-1:0][AW-1:0] w_idx;
  logic [NW-1:0]         w_en;
  logic [NW-1:0]         w_ld;
  logic [NW-1:0][NSRC-1:0] hit;

  assign w_idx[WST_EX]  = ex_rd;
  assign w_en[WST_EX]   = ex_wr;
  assign w_ld[WST_EX]   = ex_ld;
  assign w_idx[WST_MEM] = mem_rd;
  assign w_en[WST_MEM]  = mem_wr;
  assign w_ld[WST_MEM]  = mem_ld;

  for (genvar w = 0; w < NW; w++) begin : g_stage
    for (genvar s = 0; s < NSRC; s++) begin : g_src
      hzd_src_cmp #(.AW(AW)) u_cmp (
        .src_idx  (src_idx[s]),
        .src_used (src_used[s]),
        .wr_idx   (w_idx[w]),
        .wr_en    (w_en[w]),
        .hit      (hit[w][s])
      );
    end
  end

  logic any_ex, any_mem;
  logic load_use, early_ex, early_mem_load;

  assign any_ex  = |hit[WST_EX];
  assign any_mem = |hit[WST_MEM];

  // load result reaches execute only after one bubble
  assign load_use       = any_ex && w_ld[WST_EX];
  // decode-stage consumers cannot take a result still being computed
  assign early_ex       = early_need && any_ex;
  // load data reaches the decode forwarding path only from write-back
  assign early_mem_load = early_need && any_mem && w_ld[WST_MEM];

  assign stall = load_use || early_ex || early_mem_load;
endmodule

// File: rtl/hzd_redirect.sv
module hzd_redirect
  import hzd_pkg::*;
(
  input  xfer_e xfer,
  input  logic  br_taken,
  input  logic  stall,
  output logic  flush
);
  logic want;
  always_comb begin
    unique case (xfer)
      XFER_DIRECT, XFER_INDIR: want = 1'b1;
      XFER_BRANCH:             want = br_taken;
      default:                 want = 1'b0;
    endcase
  end
  // a held transfer resolves later, so the flush waits with it
  assign flush = want && !stall;
endmodule

// File: rtl/hzd_unit.sv
module hzd_unit
  import hzd_pkg::*;
#(
  parameter int AW = REG_AW_DEF
) (
  input  logic [AW-1:0] id_rs1,
  input  logic [AW-1:0] id_rs2,
  input  logic          id_rs1_used,
  input  logic          id_rs2_used,
  input  logic          id_is_branch,
  input  logic          id_is_jal,
  input  logic          id_is_jalr,
  input  logic          id_branch_taken,
  input  logic [AW-1:0] ex_rd,
  input  logic          ex_reg_write,
  input  logic          ex_mem_read,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_reg_write,
  input  logic          mem_mem_read,
  output logic          pc_hold,
  output logic          ifid_hold,
  output logic          idex_bubble,
  output logic          ifid_flush
);
  xfer_e xfer;
  logic  early_need;
  logic  stall;
  logic [NUM_SRC-1:0][AW-1:0] src_idx;
  logic [NUM_SRC-1:0]         src_used;

  assign xfer       = classify(id_is_branch, id_is_jal, id_is_jalr);
  assign early_need = (xfer == XFER_BRANCH) || (xfer == XFER_INDIR);

  assign src_idx[0]  = id_rs1;
  assign src_idx[1]  = id_rs2;
  assign src_used[0] = id_rs1_used;
  assign src_used[1] = id_rs2_used;

  hzd_stall_eval #(.AW(AW), .NSRC(NUM_SRC)) u_stall (
    .src_idx    (src_idx),
    .src_used   (src_used),
    .early_need (early_need),
    .ex_rd      (ex_rd),
    .ex_wr      (ex_reg_write),
    .ex_ld      (ex_mem_read),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_reg_write),
    .mem_ld     (mem_mem_read),
    .stall      (stall)
  );

  hzd_redirect u_redir (
    .xfer     (xfer),
    .br_taken (id_branch_taken),
    .stall    (stall),
    .flush    (ifid_flush)
  );

  assign pc_hold     = stall;
  assign ifid_hold   = stall;
  assign idex_bubble = stall;
endmodule

// File: rtl/hzd_unit_chk.sv
module hzd_unit_chk #(
  parameter int AW = 5
) (
  input logic [AW-1:0] id_rs1,
  input logic          id_rs1_used,
  input logic          id_is_branch,
  input logic          id_is_jal,
  input logic          id_is_jalr,
  input logic          id_rs2_used,
  input logic [AW-1:0] ex_rd,
  input logic          ex_reg_write,
  input logic          ex_mem_read,
  input logic [AW-1:0] mem_rd,
  input logic          mem_reg_write,
  input logic          pc_hold,
  input logic          ifid_hold,
  input logic          idex_bubble,
  input logic          ifid_flush
);
  localparam logic [AW-1:0] Z = '0;

  always_comb begin
    // R1
    load_use_hold_chk: assert (!(ex_reg_write && ex_mem_read && id_rs1_used &&
                                 ex_rd != Z && ex_rd == id_rs1) || pc_hold);
    // R2
    hold_outputs_agree_chk: assert (pc_hold == ifid_hold && ifid_hold == idex_bubble);
    // R6
    zero_dest_quiet_chk: assert (!(ex_rd == Z && mem_rd == Z) || !pc_hold);
    // R10
    no_writer_quiet_chk: assert (!(!ex_reg_write && !mem_reg_write) || !pc_hold);
    // R9
    stall_beats_flush_chk: assert (!(pc_hold && ifid_flush));
    // R8
    plain_no_flush_chk: assert (id_is_branch || id_is_jal || id_is_jalr || !ifid_flush);
    // R8
    direct_jump_flush_chk: assert (!(id_is_jal && !id_rs1_used && !id_rs2_used) || ifid_flush);
  end
endmodule

bind hzd_unit hzd_unit_chk #(.AW(AW)) u_chk (
  .id_rs1        (id_rs1),
  .id_rs1_used   (id_rs1_used),
  .id_is_branch  (id_is_branch),
  .id_is_jal     (id_is_jal),
  .id_is_jalr    (id_is_jalr),
  .id_rs2_used   (id_rs2_used),
  .ex_rd         (ex_rd),
  .ex_reg_write  (ex_reg_write),
  .ex_mem_read   (ex_mem_read),
  .mem_rd        (mem_rd),
  .mem_reg_write (mem_reg_write),
  .pc_hold       (pc_hold),
  .ifid_hold     (ifid_hold),
  .idex_bubble   (idex_bubble),
  .ifid_flush    (ifid_flush)
);

// File: tb/hzd_unit_tb.sv
module hzd_unit_tb;
  localparam int AW = 5;
  localparam logic [3:0] NONE  = 4'b0000;
  localparam logic [3:0] STALL = 4'b1110;
  localparam logic [3:0] FLUSH = 4'b0001;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [AW-1:0] id_rs1, id_rs2, ex_rd, mem_rd;
  logic id_rs1_used, id_rs2_used, id_is_branch, id_is_jal, id_is_jalr, id_branch_taken;
  logic ex_reg_write, ex_mem_read, mem_reg_write, mem_mem_read;
  logic pc_hold, ifid_hold, idex_bubble, ifid_flush;

  int n_chk = 0;
  int n_bad = 0;

  hzd_unit #(.AW(AW)) u_dut (
    .id_rs1(id_rs1), .id_rs2(id_rs2),
    .id_rs1_used(id_rs1_used), .id_rs2_used(id_rs2_used),
    .id_is_branch(id_is_branch), .id_is_jal(id_is_jal), .id_is_jalr(id_is_jalr),
    .id_branch_taken(id_branch_taken),
    .ex_rd(ex_rd), .ex_reg_write(ex_reg_write), .ex_mem_read(ex_mem_read),
    .mem_rd(mem_rd), .mem_reg_write(mem_reg_write), .mem_mem_read(mem_mem_read),
    .pc_hold(pc_hold), .ifid_hold(ifid_hold), .idex_bubble(idex_bubble),
    .ifid_flush(ifid_flush)
  );

  // decode instruction kinds used by the bench
  typedef enum int {K_ALU2, K_ALU1, K_BR, K_JAL, K_JALR, K_LUI} kind_e;

  task automatic set_id(kind_e k, int r1, int r2, bit taken);
    id_rs1 = AW'(r1); id_rs2 = AW'(r2);
    id_is_branch = (k == K_BR); id_is_jal = (k == K_JAL); id_is_jalr = (k == K_JALR);
    id_branch_taken = taken;
    id_rs1_used = (k == K_ALU2) || (k == K_ALU1) || (k == K_BR) || (k == K_JALR);
    id_rs2_used = (k == K_ALU2) || (k == K_BR);
  endtask

  // w: writes, l: load
  task automatic set_ex(int rd, bit w, bit l);
    ex_rd = AW'(rd); ex_reg_write = w; ex_mem_read = l;
  endtask

  task automatic set_mem(int rd, bit w, bit l);
    mem_rd = AW'(rd); mem_reg_write = w; mem_mem_read = l;
  endtask

  task automatic check(string req, logic [3:0] exp);
    logic [3:0] got;
    @(negedge clk);
    got = {pc_hold, ifid_hold, idex_bubble, ifid_flush};
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    set_id(K_LUI, 0, 0, 1'b0);
    set_ex(0, 1'b0, 1'b0);
    set_mem(0, 1'b0, 1'b0);
  endtask

  task automatic t_reset();
    idle();
    check("R2 idle", NONE);
  endtask

  task automatic t_load_use();
    idle(); set_id(K_ALU2, 7, 3, 0); set_ex(7, 1, 1);
    check("R1 rs1 load-use", STALL);
    set_id(K_ALU2, 4, 9, 0); set_ex(9, 1, 1);
    check("R1 rs2 load-use", STALL);
    set_id(K_ALU2, 4, 8, 0); set_ex(9, 1, 1);
    check("R2 no match no stall", NONE);
  endtask

  task automatic t_ex_alu_early();
    idle(); set_id(K_BR, 12, 13, 1); set_ex(13, 1, 0);
    check("R3 branch on ALU in EX", STALL);
    set_id(K_JALR, 6, 0, 0); set_ex(6, 1, 0);
    check("R3 jalr on ALU in EX", STALL);
  endtask

  task automatic t_mem_early();
    idle(); set_id(K_BR, 20, 21, 0); set_mem(20, 1, 1);
    check("R4 branch on load in MEM", STALL);
    set_mem(20, 1, 0);
    check("R4 branch on ALU in MEM no stall", NONE);
    set_id(K_JALR, 15, 0, 0); set_mem(15, 1, 1);
    check("R4 jalr on load in MEM", STALL);
  endtask

  task automatic t_forwardable();
    idle(); set_id(K_ALU2, 3, 4, 0); set_ex(3, 1, 0);
    check("R5 ALU on ALU in EX", NONE);
    set_ex(0, 0, 0); set_mem(4, 1, 1);
    check("R5 ALU on load in MEM", NONE);
  endtask

  task automatic t_zero();
    idle(); set_id(K_ALU2, 0, 0, 0); set_ex(0, 1, 1);
    check("R6 x0 load in EX", NONE);
    set_id(K_BR, 0, 0, 0); set_ex(0, 1, 0); set_mem(0, 1, 1);
    check("R6 x0 branch sources", NONE);
  endtask

  task automatic t_unused();
    idle(); set_id(K_ALU1, 2, 11, 0); set_ex(11, 1, 1);
    check("R7 unused rs2 ignored", NONE);
    set_id(K_JAL, 5, 5, 0); set_ex(5, 1, 1);
    check("R7 jal sources ignored", FLUSH);
    set_id(K_LUI, 5, 5, 0);
    check("R7 lui sources ignored", NONE);
  endtask

  task automatic t_flush();
    idle(); set_id(K_JAL, 0, 0, 0);
    check("R8 jal flush", FLUSH);
    set_id(K_JALR, 1, 0, 0);
    check("R8 jalr flush", FLUSH);
    set_id(K_BR, 1, 2, 1);
    check("R8 taken branch flush", FLUSH);
    set_id(K_BR, 1, 2, 0);
    check("R8 not-taken branch", NONE);
    set_id(K_ALU2, 1, 2, 1);
    check("R8 plain instr no flush", NONE);
  endtask

  task automatic t_priority();
    idle(); set_id(K_BR, 8, 9, 1); set_ex(9, 1, 0);
    check("R9 stall beats branch flush", STALL);
    set_id(K_JALR, 10, 0, 0); set_ex(0, 0, 0); set_mem(10, 1, 1);
    check("R9 stall beats jalr flush", STALL);
  endtask

  task automatic t_nowrite();
    idle(); set_id(K_BR, 14, 16, 0); set_ex(14, 0, 1); set_mem(16, 0, 1);
    check("R10 non-writers ignored", NONE);
  endtask

  task automatic t_sequence();
    // load x7 then dependent ALU op
    idle(); set_id(K_ALU2, 7, 1, 0); set_ex(7, 1, 1);
    check("R11 load-use cycle 1", STALL);
    set_ex(0, 0, 0); set_mem(7, 1, 1);
    check("R11 load-use resumes", NONE);
    // load x5 then dependent taken branch
    idle(); set_id(K_BR, 5, 6, 1); set_ex(5, 1, 1);
    check("R11 load-branch cycle 1", STALL);
    set_ex(0, 0, 0); set_mem(5, 1, 1);
    check("R11 load-branch cycle 2", STALL);
    set_mem(0, 0, 0);
    check("R11 load-branch resolves", FLUSH);
  endtask

  initial begin
    idle();
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_load_use();
    t_ex_alu_early();
    t_mem_early();
    t_forwardable();
    t_zero();
    t_unused();
    t_flush();
    t_priority();
    t_nowrite();
    t_sequence();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule